// File: doc/BRIEF.md
# Parallel Two-Dimensional Extended-BCH Product Encoder

This block turns eleven parallel information streams into a 16×16 product-code matrix, one column per clock. Every one of the eleven rows has its own bit-serial encoder. Each row encoder passes its eleven information bits straight through. It then shifts out four remainder bits from a division by x^4+x+1 and closes with an even-parity bit. On every clock the eleven row outputs form an 11-bit column slice. A combinational encoder applies the same systematic extended (16,11) code to that slice, so a complete 16-bit column of the code matrix leaves the block each clock. No matrix buffer sits between the row stage and the column stage.

The input side is a valid/ready stream. The block accepts a beat when `in_valid` and `in_ready` are both high. One beat carries one column of information bits, with bit i belonging to row i. After eleven accepted beats, `in_ready` goes low for five clocks while the row parity drains. During that time `in_valid` is ignored. While `in_ready` is high, a source may hold `in_valid` low for any number of clocks. This stalls the block with no loss of state. The output side has no back-pressure: the consumer must take each column in the cycle where `out_valid` is high. `out_sof` marks the first column of each matrix.

Top module: `pcenc_top`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_sof` is 0.
- R2: `in_ready` stays high until eleven beats have been accepted. It then stays low for exactly five clocks and returns high on the sixth. Any `in_valid` or `in_data` presented while it is low has no effect on the output.
- R3: While `in_ready` is high and `in_valid` is low, no column is produced, and the encoding state is held unchanged for the next accepted beat.
- R4: Output bit i (for rows 0 to 10) follows the row code across the 16 columns. Columns 0–10 carry `in_data[i]` of the accepted beats in order, and the first beat is the highest-degree coefficient. Columns 11–14 carry the remainder of x^4·m(x) modulo x^4+x+1, highest-degree coefficient first. Column 15 carries the even parity over columns 0–14.
- R5: Every output column is a codeword of the same code. Bits 0–10 hold the row values, with bit 0 as the highest-degree coefficient. Bits 11–14 hold the remainder, x^3 coefficient first. Bit 15 makes the 16-bit column even parity.
- R6: `out_valid` is high exactly one clock after each accepted beat and after each of the five drain clocks. A matrix therefore appears as 16 consecutive columns once its eleven beats arrive without gaps.
- R7: `out_sof` is high together with `out_valid` on column 0 of each matrix, and never at any other time.
- R8: A new matrix may start on the clock where `in_ready` returns high, so back-to-back matrices give an unbroken run of output columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Information beat present |
| in_ready | output | 1 | Block can take a beat this clock |
| in_data | input | 11 | One information bit per row, bit i for row i |
| out_valid | output | 1 | Output column present |
| out_sof | output | 1 | First column of a matrix |
| out_data | output | 16 | One code-matrix column, bit i for row i |

## Verification
The bench targets the drain window. It holds `in_valid` high with junk data while `in_ready` is low. A controller that accepted a beat there would corrupt the parity columns, and a drain of the wrong length would either swallow the first beat of the next matrix or let it collide with parity. Gaps in `in_valid` in the middle of a matrix expose a row encoder that advances without a beat, which would shift the information bits into wrong columns. Single set bits at the first and last positions of the matrix expose a reversed bit or coefficient order, because the parity then lands in the wrong rows. Back-to-back matrices expose a remainder or parity register that is not cleared between matrices.

// File: rtl/pcenc_pkg.sv
`timescale 1ns/1ps
package pcenc_pkg;
  // default code geometry: extended (16,11) built on a degree-4 generator
  localparam int unsigned CODE_N = 16;
  localparam int unsigned CODE_K = 11;
  localparam int unsigned PAR_M  = 4;
  // generator x^4+x+1 without its leading term
  localparam logic [PAR_M-1:0] GEN_TAPS = 4'b0011;

  // one step of a divide-by-generator shift register, message fed at the top
  function automatic logic [PAR_M-1:0] div_step(input logic [PAR_M-1:0] rem,
                                               input logic din,
                                               input logic [PAR_M-1:0] taps);
    logic fb;
    fb = din ^ rem[PAR_M-1];
    return {rem[PAR_M-2:0], 1'b0} ^ (fb ? taps : '0);
  endfunction
endpackage

// File: rtl/pcenc_ctrl.sv
`timescale 1ns/1ps
module pcenc_ctrl #(
  parameter int unsigned N     = pcenc_pkg::CODE_N,
  parameter int unsigned K     = pcenc_pkg::CODE_K,
  parameter int unsigned CNT_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             advance,
  output logic [CNT_W-1:0] col
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(N - 1);
  localparam logic [CNT_W-1:0] INFO_C = CNT_W'(K);

  logic [CNT_W-1:0] cnt;

  // information phase waits for the source, the parity drain runs on its own
  assign in_ready = (cnt < INFO_C);
  assign advance  = in_ready ? in_valid : 1'b1;
  assign col      = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (advance) begin
      cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
    end
  end

  // R2
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> cnt == '0);
endmodule

// File: rtl/pcenc_row_enc.sv
`timescale 1ns/1ps
module pcenc_row_enc #(
  parameter int unsigned N     = pcenc_pkg::CODE_N,
  parameter int unsigned K     = pcenc_pkg::CODE_K,
  parameter int unsigned M     = pcenc_pkg::PAR_M,
  parameter logic [M-1:0] TAPS = pcenc_pkg::GEN_TAPS,
  parameter int unsigned CNT_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [CNT_W-1:0] col,
  input  logic             din,
  output logic             dout
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(N - 1);
  localparam logic [CNT_W-1:0] INFO_C = CNT_W'(K);

  logic [M-1:0] rem;
  logic         par;

  always_comb begin
    if (col < INFO_C)       dout = din;
    else if (col != LAST_C) dout = rem[M-1];
    else                    dout = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      par <= 1'b0;
    end else if (advance) begin
      if (col == LAST_C) begin
        rem <= '0;
        par <= 1'b0;
      end else if (col < INFO_C) begin
        rem <= pcenc_pkg::div_step(rem, din, TAPS);
        par <= par ^ din;
      end else begin
        rem <= {rem[M-2:0], 1'b0};
        par <= par ^ rem[M-1];
      end
    end
  end

  // R4
  row_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && col == LAST_C) |-> rem == '0);
endmodule

// File: rtl/pcenc_col_enc.sv
`timescale 1ns/1ps
module pcenc_col_enc #(
  parameter int unsigned N     = pcenc_pkg::CODE_N,
  parameter int unsigned K     = pcenc_pkg::CODE_K,
  parameter int unsigned M     = pcenc_pkg::PAR_M,
  parameter logic [M-1:0] TAPS = pcenc_pkg::GEN_TAPS
) (
  input  logic [K-1:0] slice,
  output logic [N-1:0] column
);
  logic [M-1:0] rem;

  always_comb begin
    rem = '0;
    for (int i = 0; i < K; i++) begin
      rem = pcenc_pkg::div_step(rem, slice[i], TAPS);
    end
  end

  assign column[K-1:0] = slice;

  generate
    for (genvar j = 0; j < M; j++) begin : g_par
      assign column[K+j] = rem[M-1-j];
    end
  endgenerate

  assign column[N-1] = ^column[N-2:0];
endmodule

// File: rtl/pcenc_top.sv
`timescale 1ns/1ps
module pcenc_top #(
  parameter int unsigned N     = pcenc_pkg::CODE_N,
  parameter int unsigned K     = pcenc_pkg::CODE_K,
  parameter int unsigned M     = pcenc_pkg::PAR_M,
  parameter logic [M-1:0] TAPS = pcenc_pkg::GEN_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_data,
  output logic         out_valid,
  output logic         out_sof,
  output logic [N-1:0] out_data
);
  localparam int unsigned CNT_W = $clog2(N);

  logic             advance;
  logic [CNT_W-1:0] col;
  logic [K-1:0]     slice;
  logic [N-1:0]     column;

  pcenc_ctrl #(.N(N), .K(K), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .advance  (advance),
    .col      (col)
  );

  generate
    for (genvar r = 0; r < K; r++) begin : g_row
      pcenc_row_enc #(.N(N), .K(K), .M(M), .TAPS(TAPS), .CNT_W(CNT_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .col     (col),
        .din     (in_data[r]),
        .dout    (slice[r])
      );
    end
  endgenerate

  pcenc_col_enc #(.N(N), .K(K), .M(M), .TAPS(TAPS)) u_col (
    .slice  (slice),
    .column (column)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= advance;
      out_sof   <= advance && (col == '0);
      if (advance) out_data <= column;
    end
  end

  // independent count of emitted columns, used only by the checks below
  logic [CNT_W-1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= '0;
    else if (out_valid) seen <= (seen == CNT_W'(N - 1)) ? '0 : seen + 1'b1;
  end

  function automatic logic [M-1:0] col_syndrome(input logic [N-2:0] c);
    logic [M-1:0] r;
    r = '0;
    for (int i = 0; i < N - 1; i++) r = pcenc_pkg::div_step(r, c[i], TAPS);
    return r;
  endfunction

  initial begin
    // R5
    geometry_chk: assert (N == K + M + 1);
  end

  // R7
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R7
  sof_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == (seen == '0)));

  // R5
  col_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^out_data) == 1'b0);

  // R5
  col_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> col_syndrome(out_data[N-2:0]) == '0);

  // R6
  drain_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);

  // R3
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/tb_pcenc_top.sv
`timescale 1ns/1ps
module tb_pcenc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_data = '0;
  logic        out_valid;
  logic        out_sof;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_q[$];
  bit          sof_q[$];
  int          run_len = 0;
  int          max_run = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  pcenc_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  function automatic logic [15:0] ref_cw(input logic [10:0] m);
    logic [14:0] v;
    logic [15:0] c;
    v = '0;
    for (int i = 0; i < 11; i++) v[14-i] = m[i];
    for (int d = 14; d >= 4; d--) if (v[d]) v[d -: 5] = v[d -: 5] ^ 5'b10011;
    c = '0;
    c[10:0] = m;
    c[11] = v[3]; c[12] = v[2]; c[13] = v[1]; c[14] = v[0];
    c[15] = ^c[14:0];
    return c;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // output monitor: columns compared in arrival order (R4, R5, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        run_len++;
        if (run_len > max_run) max_run = run_len;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected column", {16'h0, out_data}, 32'h0);
        end else begin
          logic [15:0] e;
          bit s;
          e = exp_q.pop_front();
          s = sof_q.pop_front();
          check(out_data == e, "R4/R5", "column data", {16'h0, out_data}, {16'h0, e});
          check(out_sof == s, "R7", "frame start", {31'h0, out_sof}, {31'h0, s});
        end
      end else begin
        run_len = 0;
        if (out_sof) check(1'b0, "R7", "sof without valid", 32'h1, 32'h0);
      end
    end
  end

  // info[row] holds the 11 information bits of that row, bit j = column j
  task automatic send_matrix(input logic [10:0] info [11], input int stall_every,
                             input bit junk_in_drain);
    logic [15:0] rows [11];
    int drain;
    for (int i = 0; i < 11; i++) rows[i] = ref_cw(info[i]);
    for (int j = 0; j < 16; j++) begin
      logic [10:0] sl;
      for (int i = 0; i < 11; i++) sl[i] = rows[i][j];
      exp_q.push_back(ref_cw(sl));
      sof_q.push_back(j == 0);
    end
    for (int j = 0; j < 11; j++) begin
      if (stall_every != 0 && (j % stall_every) == 1) begin
        in_valid = 1'b0;
        in_data  = 11'h5A5;
        repeat (3) @(negedge clk);
      end
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      for (int i = 0; i < 11; i++) in_data[i] = info[i][j];
      @(negedge clk);
    end
    in_valid = junk_in_drain;
    in_data  = 11'h7FF;
    drain = 0;
    while (!in_ready && drain < 20) begin
      drain++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_data  = '0;
    // R2: ready low for exactly five clocks after the eleventh beat
    check(drain == 5, "R2", "drain length", drain, 5);
  endtask

  task automatic wait_flush();
    @(negedge clk);
    // R6: last column visible one clock after the final drain cycle
    check(exp_q.size() == 0, "R6", "columns outstanding", exp_q.size(), 0);
    exp_q.delete();
    sof_q.delete();
  endtask

  task automatic fill_rand(output logic [10:0] m [11]);
    for (int i = 0; i < 11; i++) begin
      seed = next_rand(seed);
      m[i] = seed[10:0];
    end
  endtask

  task automatic test_reset();
    // R1
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_sof == 1'b0, "R1", "out_sof after reset", out_sof, 0);
  endtask

  task automatic test_constant(input logic [10:0] v);
    logic [10:0] m [11];
    for (int i = 0; i < 11; i++) m[i] = v;
    send_matrix(m, 0, 1'b0);
    wait_flush();
  endtask

  task automatic test_single_bits();
    logic [10:0] m [11];
    for (int i = 0; i < 11; i++) m[i] = '0;
    m[0][0] = 1'b1;             // R4: first beat, first row
    send_matrix(m, 0, 1'b0);
    wait_flush();
    for (int i = 0; i < 11; i++) m[i] = '0;
    m[10][10] = 1'b1;           // R4: last beat, last row
    send_matrix(m, 0, 1'b0);
    wait_flush();
  endtask

  task automatic test_random(input int count);
    logic [10:0] m [11];
    for (int k = 0; k < count; k++) begin
      fill_rand(m);
      send_matrix(m, 0, 1'b0);
      wait_flush();
    end
  endtask

  task automatic test_stall();
    logic [10:0] m [11];
    // R3: gaps in in_valid inside the information phase
    fill_rand(m);
    send_matrix(m, 3, 1'b0);
    wait_flush();
    fill_rand(m);
    send_matrix(m, 2, 1'b0);
    wait_flush();
  endtask

  task automatic test_drain_junk();
    logic [10:0] m [11];
    // R2: valid held high with junk while ready is low
    fill_rand(m);
    send_matrix(m, 0, 1'b1);
    wait_flush();
    check(in_ready == 1'b1, "R2", "ready after drain", in_ready, 1);
  endtask

  task automatic test_back_to_back();
    logic [10:0] m [11];
    max_run = 0;
    for (int k = 0; k < 3; k++) begin
      fill_rand(m);
      send_matrix(m, 0, 1'b1);
    end
    wait_flush();
    // R8: three matrices give 48 unbroken columns
    check(max_run >= 48, "R8", "continuous run", max_run, 48);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_constant(11'h000);
    test_constant(11'h7FF);
    test_single_bits();
    test_random(6);
    test_stall();
    test_drain_junk();
    test_back_to_back();
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule